// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, through a pair of directional paths. Each path owns a storage register with its own capture strobe, a selector that chooses between the live value of the source bus and the stored copy, and a drive enable. The A-to-B enable is active high and the B-to-A enable is active low. Each bus pin is modelled as three signals: an input value, an output value and a drive flag. The surrounding logic resolves the real bus from these and feeds the resolved value back into the input.

All storage runs on one system clock. A capture strobe counts as rising on the first clock edge at which it is seen high after being seen low. Capture is never gated by the enables, so the block can record bus traffic while it is isolated. A parameter makes every driven output the bit-wise complement of the selected data. The registers always hold the true bus value.

Enabling both directions is legal only when both selectors pick stored data. In that case each bus carries the other side's register. If either selector picks live data in that state, a combinational loop would form. The block raises an error flag instead and withdraws drive on every side that is set to live data.

Top module: `regbus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers to zero. After reset, selecting stored data on both sides drives 0x00 on both buses, or 0xFF with inversion on.
- R2: The A-side register loads the resolved bus A value at the first clock edge at which `cap_ab_i` is high after being low. At every other edge it holds its value.
- R3: The B-side register loads the resolved bus B value at the first clock edge at which `cap_ba_i` is high after being low. At every other edge it holds its value.
- R4: Capture happens whatever the enables and selectors are set to, including isolation (`oe_ab_i` low, `oe_ba_n_i` high), where neither bus is driven.
- R5: `b_oe_o` is high only when `oe_ab_i` is 1, and `a_oe_o` is high only when `oe_ba_n_i` is 0. Outside the loop case of R9, each follows its enable exactly.
- R6: While bus B is driven, `sel_ab_i` = 0 puts the live bus A value on `b_out_o`, and `sel_ab_i` = 1 puts the A-side register on it.
- R7: While bus A is driven, `sel_ba_i` = 0 puts the live bus B value on `a_out_o`, and `sel_ba_i` = 1 puts the B-side register on it.
- R8: With `INVERT` = 1, every driven output is the complement of the selected data. Registers store the uninverted bus value, so data captured and then driven back out is complemented exactly once.
- R9: When `oe_ab_i` = 1 and `oe_ba_n_i` = 0 and either selector is 0, `loop_err_o` is 1, and each side whose selector is 0 stops driving. When both selectors are 1, both buses are driven from the registers and `loop_err_o` is 0.
- R10: Suppose bus B is driven with live A data and both strobes rise at the same edge. The A-side register then takes the bus A value and the B-side register takes the value driven on bus B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_ab_i | input | 1 | Capture strobe for the A-side register |
| cap_ba_i | input | 1 | Capture strobe for the B-side register |
| sel_ab_i | input | 1 | Bus B source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Bus A source: 0 live B, 1 stored B |
| oe_ab_i | input | 1 | Drive bus B, active high |
| oe_ba_n_i | input | 1 | Drive bus A, active low |
| a_in_i | input | W | Resolved bus A value |
| a_out_o | output | W | Value offered to bus A |
| a_oe_o | output | 1 | Block drives bus A |
| b_in_i | input | W | Resolved bus B value |
| b_out_o | output | W | Value offered to bus B |
| b_oe_o | output | 1 | Block drives bus B |
| loop_err_o | output | 1 | Both enables active with a live selector |

## Verification
The bench builds two copies side by side from the same stimulus: one with `INVERT` = 0 and one with `INVERT` = 1, both with `W` = 8. Each copy sits on its own resolved buses. The non-inverting copy shows the plain store-both and pass-through cases. The inverting copy shows that data captured from a driven bus and sent back is complemented only once. Both copies are checked against all enable and selector combinations, including the loop-guard state and capture during isolation.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    // Where a bus side takes its driven value from
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2
    } src_e;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] stored_o
);

    typedef struct packed {
        logic         strobe_prev;
        logic [W-1:0] data;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe_i;
        if (strobe_i && !st_q.strobe_prev) begin
            st_d.data = bus_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stored_o = st_q.data;

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
    import regbus_xcvr_pkg::*;
(
    input  logic en_ab_i,
    input  logic en_ba_i,
    input  logic sel_ab_i,
    input  logic sel_ba_i,
    output src_e src_b_o,
    output src_e src_a_o,
    output logic loop_err_o
);

    logic both_on;
    logic guard;

    assign both_on = en_ab_i && en_ba_i;
    assign guard   = both_on && (!sel_ab_i || !sel_ba_i);

    always_comb begin
        src_b_o = SRC_NONE;
        if (en_ab_i) begin
            if (sel_ab_i) begin
                src_b_o = SRC_STORED;
            end else if (!guard) begin
                src_b_o = SRC_LIVE;
            end
        end
    end

    always_comb begin
        src_a_o = SRC_NONE;
        if (en_ba_i) begin
            if (sel_ba_i) begin
                src_a_o = SRC_STORED;
            end else if (!guard) begin
                src_a_o = SRC_LIVE;
            end
        end
    end

    assign loop_err_o = guard;

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import regbus_xcvr_pkg::*;
#(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  src_e         src_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] out_o,
    output logic         oe_o
);

    logic [W-1:0] picked;

    assign picked = (src_i == SRC_STORED) ? stored_i : live_i;
    assign oe_o   = (src_i != SRC_NONE);

    generate
        if (INVERT) begin : g_inv
            assign out_o = ~picked;
        end else begin : g_true
            assign out_o = picked;
        end
    endgenerate

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_ab_i,
    input  logic         cap_ba_i,
    input  logic         sel_ab_i,
    input  logic         sel_ba_i,
    input  logic         oe_ab_i,
    input  logic         oe_ba_n_i,
    input  logic [W-1:0] a_in_i,
    output logic [W-1:0] a_out_o,
    output logic         a_oe_o,
    input  logic [W-1:0] b_in_i,
    output logic [W-1:0] b_out_o,
    output logic         b_oe_o,
    output logic         loop_err_o
);

    logic [W-1:0] stored_a;
    logic [W-1:0] stored_b;
    src_e         src_a;
    src_e         src_b;

    xcvr_capture #(.W(W)) u_cap_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cap_ab_i),
        .bus_i    (a_in_i),
        .stored_o (stored_a)
    );

    xcvr_capture #(.W(W)) u_cap_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cap_ba_i),
        .bus_i    (b_in_i),
        .stored_o (stored_b)
    );

    xcvr_ctrl u_ctrl (
        .en_ab_i    (oe_ab_i),
        .en_ba_i    (!oe_ba_n_i),
        .sel_ab_i   (sel_ab_i),
        .sel_ba_i   (sel_ba_i),
        .src_b_o    (src_b),
        .src_a_o    (src_a),
        .loop_err_o (loop_err_o)
    );

    xcvr_path #(.W(W), .INVERT(INVERT)) u_path_b (
        .src_i    (src_b),
        .live_i   (a_in_i),
        .stored_i (stored_a),
        .out_o    (b_out_o),
        .oe_o     (b_oe_o)
    );

    xcvr_path #(.W(W), .INVERT(INVERT)) u_path_a (
        .src_i    (src_a),
        .live_i   (b_in_i),
        .stored_i (stored_b),
        .out_o    (a_out_o),
        .oe_o     (a_oe_o)
    );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_ab_i,
    input logic         cap_ba_i,
    input logic         sel_ab_i,
    input logic         sel_ba_i,
    input logic         oe_ab_i,
    input logic         oe_ba_n_i,
    input logic [W-1:0] a_in_i,
    input logic [W-1:0] a_out_o,
    input logic         a_oe_o,
    input logic [W-1:0] b_in_i,
    input logic [W-1:0] b_out_o,
    input logic         b_oe_o,
    input logic         loop_err_o,
    input logic [W-1:0] stored_a,
    input logic [W-1:0] stored_b
);

    assert_cap_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ab_i && !$past(cap_ab_i)) |=> (stored_a == $past(a_in_i)));

    assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ab_i && !$past(cap_ab_i)) |=> $stable(stored_a));

    assert_cap_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ba_i && !$past(cap_ba_i)) |=> (stored_b == $past(b_in_i)));

    assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ba_i && !$past(cap_ba_i)) |=> $stable(stored_b));

    assert_b_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ab_i |-> !b_oe_o);

    assert_a_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n_i |-> !a_oe_o);

    assert_b_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe_o && sel_ab_i) |-> (b_out_o == ((INVERT != 0) ? ~stored_a : stored_a)));

    assert_b_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe_o && !sel_ab_i) |-> (b_out_o == ((INVERT != 0) ? ~a_in_i : a_in_i)));

    assert_a_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && sel_ba_i) |-> (a_out_o == ((INVERT != 0) ? ~stored_b : stored_b)));

    assert_a_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && !sel_ba_i) |-> (a_out_o == ((INVERT != 0) ? ~b_in_i : b_in_i)));

    assert_no_live_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_o && b_oe_o) |-> (sel_ab_i && sel_ba_i));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_err_o |-> (oe_ab_i && !oe_ba_n_i && !(sel_ab_i && sel_ba_i)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (.*);

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic [7:0] ext_a, ext_b;

    logic [7:0] a_in_w [2];
    logic [7:0] a_out_w [2];
    logic [7:0] b_in_w [2];
    logic [7:0] b_out_w [2];
    logic       a_oe_w [2];
    logic       b_oe_w [2];
    logic       err_w [2];

    assign a_in_w[0] = a_oe_w[0] ? a_out_w[0] : ext_a;
    assign b_in_w[0] = b_oe_w[0] ? b_out_w[0] : ext_b;
    assign a_in_w[1] = a_oe_w[1] ? a_out_w[1] : ext_a;
    assign b_in_w[1] = b_oe_w[1] ? b_out_w[1] : ext_b;

    regbus_xcvr #(.W(8), .INVERT(1'b0)) i_regbus_xcvr (
        .clk(clk), .rst_n(rst_n), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
        .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n),
        .a_in_i(a_in_w[0]), .a_out_o(a_out_w[0]), .a_oe_o(a_oe_w[0]),
        .b_in_i(b_in_w[0]), .b_out_o(b_out_w[0]), .b_oe_o(b_oe_w[0]),
        .loop_err_o(err_w[0])
    );

    regbus_xcvr #(.W(8), .INVERT(1'b1)) i_regbus_xcvr_inv (
        .clk(clk), .rst_n(rst_n), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
        .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n),
        .a_in_i(a_in_w[1]), .a_out_o(a_out_w[1]), .a_oe_o(a_oe_w[1]),
        .b_in_i(b_in_w[1]), .b_out_o(b_out_w[1]), .b_oe_o(b_oe_w[1]),
        .loop_err_o(err_w[1])
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] m_reg_a [2];
    logic [7:0] m_reg_b [2];
    logic [7:0] m_abus [2];
    logic [7:0] m_bbus [2];
    logic       m_aoe [2];
    logic       m_boe [2];
    logic       m_err;
    logic       p_cap_ab, p_cap_ba;

    function automatic logic [7:0] xf(input logic [7:0] v, input int k);
        return (k == 1) ? ~v : v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model: resolve both buses from the requirement rules
    task automatic eval_model(input int k);
        logic guard;
        guard    = oe_ab && !oe_ba_n && (!sel_ab || !sel_ba);
        m_err    = guard;
        m_boe[k] = oe_ab && !(guard && !sel_ab);
        m_aoe[k] = !oe_ba_n && !(guard && !sel_ba);
        m_bbus[k] = ext_b;
        if (m_boe[k] && sel_ab) m_bbus[k] = xf(m_reg_a[k], k);
        if (!m_aoe[k])        m_abus[k] = ext_a;
        else if (sel_ba)      m_abus[k] = xf(m_reg_b[k], k);
        else                  m_abus[k] = xf(m_bbus[k], k);
        if (m_boe[k] && !sel_ab) m_bbus[k] = xf(m_abus[k], k);
    endtask

    task automatic cyc();
        #1;
        for (int k = 0; k < 2; k++) begin
            eval_model(k);
            chk("R5 b drive", {7'd0, b_oe_w[k]}, {7'd0, m_boe[k]});
            chk("R5 a drive", {7'd0, a_oe_w[k]}, {7'd0, m_aoe[k]});
            chk("R9 loop flag", {7'd0, err_w[k]}, {7'd0, m_err});
            if (m_boe[k]) chk((k == 1) ? "R8 b out" : (sel_ab ? "R6 b stored" : "R6 b live"),
                              b_out_w[k], m_bbus[k]);
            if (m_aoe[k]) chk((k == 1) ? "R8 a out" : (sel_ba ? "R7 a stored" : "R7 a live"),
                              a_out_w[k], m_abus[k]);
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (cap_ab && !p_cap_ab) m_reg_a[k] = m_abus[k];
            if (cap_ba && !p_cap_ba) m_reg_b[k] = m_bbus[k];
        end
        p_cap_ab = cap_ab;
        p_cap_ba = cap_ba;
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic oab, input logic oban, input logic sab, input logic sba);
        oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
    endtask

    task automatic pulse_caps(input logic ca, input logic cb);
        cap_ab = 1'b0; cap_ba = 1'b0; cyc();
        cap_ab = ca;   cap_ba = cb;   cyc();
        cap_ab = 1'b0; cap_ba = 1'b0; cyc();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        cap_ab = 0; cap_ba = 0; ext_a = 8'h00; ext_b = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin m_reg_a[k] = '0; m_reg_b[k] = '0; end
        p_cap_ab = 0; p_cap_ba = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: registers cleared; drive both buses from storage
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R1 b after reset", b_out_w[0], 8'h00);
        chk("R1 a after reset", a_out_w[0], 8'h00);
        chk("R1 b after reset inv", b_out_w[1], 8'hFF);
        chk("R1 a after reset inv", a_out_w[1], 8'hFF);
        cyc();

        // R4: capture during isolation
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h3C; ext_b = 8'hC3;
        pulse_caps(1'b1, 1'b1);
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        #1;
        for (int k = 0; k < 2; k++) begin
            chk("R4 R2 isolated capture A", b_out_w[k], xf(8'h3C, k));
            chk("R4 R3 isolated capture B", a_out_w[k], xf(8'hC3, k));
        end
        cyc();

        // R3 only: A strobe low, B strobe rises
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h11; ext_b = 8'h96;
        pulse_caps(1'b0, 1'b1);
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R2 A held", b_out_w[0], 8'h3C);
        chk("R3 B loaded", a_out_w[0], 8'h96);
        cyc();

        // R10: live A onto B, both strobes rise
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h5A;
        pulse_caps(1'b1, 1'b1);
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        #1;
        for (int k = 0; k < 2; k++) begin
            chk("R10 B stored from A", b_out_w[k], xf(8'h5A, k));
            chk("R10 R8 single inversion", a_out_w[k], 8'h5A);
        end
        cyc();

        // R9: loop guard
        set_ctl(1'b1, 1'b0, 1'b0, 1'b1);
        #1;
        chk("R9 flag", {7'd0, err_w[0]}, 8'd1);
        chk("R9 live side off", {7'd0, b_oe_w[0]}, 8'd0);
        chk("R9 stored side on", {7'd0, a_oe_w[0]}, 8'd1);
        cyc();

        // Random mix against the model
        for (int i = 0; i < 600; i++) begin
            logic [5:0] c;
            c = 6'($urandom);
            {cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n} = c;
            ext_a = 8'($urandom);
            ext_b = 8'($urandom);
            cyc();
        end

        finish_run();
    end

endmodule